// File: doc/BRIEF.md
# Fusing Processing-Element Array

A 4x4 grid of simple 32-bit processing elements (PEs) with nearest-neighbour links and one shared register file. Each PE holds a 16-bit configuration word that picks its operation, where its two operands come from, and whether its result is registered or passed straight through to a neighbour in the same clock. A PE in pass-through (bypass) mode feeds a dependent neighbour combinationally. A chain of up to three dependent operations therefore finishes in one clock and writes only its final result to the register file.

A host loads the configuration words one PE at a time and preloads register-file entries while the array is idle. Then `run_i` is held high for as many execute cycles as the mapped dataflow graph needs. The configuration store checks the loaded pattern of bypass links and raises `cfg_err_o` if any combinational chain would be longer than three operations or would close on itself. While that flag is high, execute cycles change nothing. Results are read back through a combinational register-file read port.

Top module: `cgra_fuse_top`

## Requirements
- R1: Configuration word layout: [15:13] operation, [12:10] operand A source, [9:7] operand B source, [6] bypass, [5:0] field. A word written with `cfg_we_i` to PE `cfg_idx_i` (PE number = row*4 + column) takes effect from the next clock.
- R2: Operations use the codes 0 none, 1 A+B, 2 A-B, 3 A shifted right logically by B[4:0], 4 A shifted left by B[4:0]. Arithmetic wraps modulo 2^32.
- R3: Operand source codes are 0 register file entry field[2:0], 1 the field zero-extended, 2 north (row-1), 3 south (row+1), 4 east (column+1), 5 west (column-1). A neighbour that lies off the grid reads as 0.
- R4: A chain of up to three dependent operations, linked through bypassed PEs, completes in a single execute cycle. The final, non-bypassed PE writes its result to register-file entry field[5:3] at that clock edge.
- R5: A bypassed PE never writes the register file. Its result reaches neighbours only combinationally.
- R6: A non-bypassed PE with an operation registers its result on each execute cycle. Neighbours see that value only on the following execute cycle, and they read 0 before the first such cycle after reset.
- R7: Independent chains in different parts of the grid execute and write back in the same cycle.
- R8: `cfg_err_o` is high whenever the loaded configuration holds a bypass chain of more than three operations or a bypass loop. While it is high, execute cycles leave the register file unchanged.
- R9: When several PEs write the same register-file entry in one cycle, the lowest-numbered PE's value is stored.
- R10: After reset every register-file entry reads 0. A host write is stored only when `run_i` is low and is ignored when `run_i` is high. `rd_data_o` shows entry `rd_addr_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_idx_i | input | 4 | PE to configure |
| cfg_word_i | input | 16 | Configuration word |
| run_i | input | 1 | Execute-cycle enable |
| host_we_i | input | 1 | Host register-file write strobe |
| host_addr_i | input | 3 | Host write entry |
| host_data_i | input | 32 | Host write data |
| rd_addr_i | input | 3 | Read-port entry |
| rd_data_o | output | 32 | Read-port data |
| cfg_err_o | output | 1 | Illegal bypass chain or loop loaded |

## Verification
A wrong bypass decision shows at the read port one execute cycle after the chain runs. A chain that should fuse would leave its destination entry stale, and a bypassed PE that writes back would clobber the entry named in its field. A stale or early registered PE value shows as a wrong destination value on the first or second execute cycle of a two-stage pipeline. A depth miscount shows on `cfg_err_o` one clock after the offending word is loaded, and leaking writes under an error show on the next read.

// File: rtl/cgra_fuse_pkg.sv
package cgra_fuse_pkg;
  localparam int GRID = 4;
  localparam int NPE  = GRID * GRID;

  typedef enum logic [2:0] {OP_NOP, OP_ADD, OP_SUB, OP_LSR, OP_LSL} op_e;
  typedef enum logic [2:0] {SRC_RF, SRC_CONST, SRC_N, SRC_S, SRC_E, SRC_W} src_e;

  typedef struct packed {
    op_e        op;
    src_e       src_a;
    src_e       src_b;
    logic       byp;
    logic [5:0] fld;   // [2:0] read entry, [5:3] write entry, whole = constant
  } pe_cfg_t;

  // neighbour PE number, -1 when off grid or not a neighbour source
  function automatic int nbr(int p, src_e s);
    int r, c;
    r = p / GRID;
    c = p % GRID;
    case (s)
      SRC_N:   return (r > 0)        ? p - GRID : -1;
      SRC_S:   return (r < GRID - 1) ? p + GRID : -1;
      SRC_E:   return (c < GRID - 1) ? p + 1    : -1;
      SRC_W:   return (c > 0)        ? p - 1    : -1;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/cgra_cfg_store.sv
module cgra_cfg_store
  import cgra_fuse_pkg::*;
#(
  parameter int MAX_CHAIN = 3,
  parameter int PASSES    = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cfg_we_i,
  input  logic [3:0]  cfg_idx_i,
  input  logic [15:0] cfg_word_i,
  output pe_cfg_t cfg_o [NPE],
  output logic    err_o
);
  localparam int DEPTH_SAT = 7;

  pe_cfg_t cfg_q [NPE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NPE; p++) cfg_q[p] <= '0;
    end else if (cfg_we_i) begin
      cfg_q[cfg_idx_i] <= pe_cfg_t'(cfg_word_i);
    end
  end

  assign cfg_o = cfg_q;

  // combinational chain depth, relaxed PASSES times; a loop keeps growing
  logic [2:0] dep [PASSES+1][NPE];
  always_comb begin
    logic [2:0] m;
    int n;
    for (int p = 0; p < NPE; p++) dep[0][p] = 3'd1;
    for (int k = 0; k < PASSES; k++) begin
      for (int p = 0; p < NPE; p++) begin
        m = '0;
        n = nbr(p, cfg_q[p].src_a);
        if (n >= 0 && cfg_q[n].byp && dep[k][n] > m) m = dep[k][n];
        n = nbr(p, cfg_q[p].src_b);
        if (n >= 0 && cfg_q[n].byp && dep[k][n] > m) m = dep[k][n];
        dep[k+1][p] = (int'(m) >= DEPTH_SAT - 1) ? 3'(DEPTH_SAT) : m + 3'd1;
      end
    end
  end

  always_comb begin
    err_o = 1'b0;
    for (int p = 0; p < NPE; p++)
      if (int'(dep[PASSES][p]) > MAX_CHAIN) err_o = 1'b1;
  end

  assert_cfg_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_q[$past(cfg_idx_i)] == pe_cfg_t'($past(cfg_word_i)));
endmodule

// File: rtl/cgra_rf.sv
module cgra_rf
  import cgra_fuse_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] pe_raddr_i [NPE],
  output logic [DW-1:0] pe_rdata_o [NPE],
  input  logic          pe_we_i    [NPE],
  input  logic [AW-1:0] pe_waddr_i [NPE],
  input  logic [DW-1:0] pe_wdata_i [NPE]
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (host_we_i && !run_i) mem[host_addr_i] <= host_data_i;
      // descending order: lowest-numbered PE lands last and wins
      for (int p = NPE - 1; p >= 0; p--)
        if (pe_we_i[p]) mem[pe_waddr_i[p]] <= pe_wdata_i[p];
    end
  end

  assign rd_data_o = mem[rd_addr_i];
  always_comb for (int p = 0; p < NPE; p++) pe_rdata_o[p] = mem[pe_raddr_i[p]];

  assert_low_pe_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_we_i[0] |=> mem[$past(pe_waddr_i[0])] == $past(pe_wdata_i[0]));
  assert_host_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !run_i) |=> mem[$past(host_addr_i)] == $past(host_data_i));
endmodule

// File: rtl/cgra_fabric.sv
module cgra_fabric
  import cgra_fuse_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 3,
  parameter int LEVELS = 3,
  localparam int SHW   = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  pe_cfg_t       cfg_i      [NPE],
  output logic [AW-1:0] rf_raddr_o [NPE],
  input  logic [DW-1:0] rf_rdata_i [NPE],
  output logic          rf_we_o    [NPE],
  output logic [AW-1:0] rf_waddr_o [NPE],
  output logic [DW-1:0] rf_wdata_o [NPE]
);
  function automatic logic [DW-1:0] alu(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_LSR:  return a >> b[SHW-1:0];
      OP_LSL:  return a << b[SHW-1:0];
      default: return '0;
    endcase
  endfunction

  logic [DW-1:0] q  [NPE];
  logic [DW-1:0] lv [LEVELS][NPE];

  // level k sees bypassed neighbours at level k-1; LEVELS bounds fused depth
  always_comb begin
    logic [DW-1:0] opv [2];
    src_e s;
    int n;
    for (int k = 0; k < LEVELS; k++) begin
      for (int p = 0; p < NPE; p++) begin
        for (int j = 0; j < 2; j++) begin
          s = (j == 0) ? cfg_i[p].src_a : cfg_i[p].src_b;
          n = 0;
          case (s)
            SRC_RF:    opv[j] = rf_rdata_i[p];
            SRC_CONST: opv[j] = DW'(cfg_i[p].fld);
            default: begin
              n = nbr(p, s);
              if (n < 0)               opv[j] = '0;
              else if (cfg_i[n].byp)   opv[j] = (k == 0) ? '0 : lv[(k == 0) ? 0 : k - 1][n];
              else                     opv[j] = q[n];
            end
          endcase
        end
        lv[k][p] = alu(cfg_i[p].op, opv[0], opv[1]);
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPE; p++) begin
      rf_raddr_o[p] = cfg_i[p].fld[AW-1:0];
      rf_waddr_o[p] = cfg_i[p].fld[2*AW-1:AW];
      rf_wdata_o[p] = lv[LEVELS-1][p];
      rf_we_o[p]    = run_i && (cfg_i[p].op != OP_NOP) && !cfg_i[p].byp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NPE; p++) q[p] <= '0;
    end else begin
      for (int p = 0; p < NPE; p++)
        if (rf_we_o[p]) q[p] <= lv[LEVELS-1][p];
    end
  end

  generate
    for (genvar g = 0; g < NPE; g++) begin : g_chk
      assert_bypass_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_i[g].byp |=> $stable(q[g]));
    end
  endgenerate
endmodule

// File: rtl/cgra_fuse_top.sv
module cgra_fuse_top
  import cgra_fuse_pkg::*;
#(
  parameter int DW        = 32,
  parameter int RF_DEPTH  = 8,
  parameter int MAX_CHAIN = 3,
  localparam int AW       = $clog2(RF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [3:0]    cfg_idx_i,
  input  logic [15:0]   cfg_word_i,
  input  logic          run_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [DW-1:0] host_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          cfg_err_o
);
  pe_cfg_t       cfg      [NPE];
  logic [AW-1:0] pe_raddr [NPE];
  logic [DW-1:0] pe_rdata [NPE];
  logic          pe_we    [NPE];
  logic [AW-1:0] pe_waddr [NPE];
  logic [DW-1:0] pe_wdata [NPE];
  logic          err;

  cgra_cfg_store #(.MAX_CHAIN(MAX_CHAIN), .PASSES(MAX_CHAIN + 1)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_word_i,
    .cfg_o(cfg), .err_o(err)
  );

  cgra_fabric #(.DW(DW), .AW(AW), .LEVELS(MAX_CHAIN)) u_fabric (
    .clk_i, .rst_ni, .run_i(run_i && !err), .cfg_i(cfg),
    .rf_raddr_o(pe_raddr), .rf_rdata_i(pe_rdata),
    .rf_we_o(pe_we), .rf_waddr_o(pe_waddr), .rf_wdata_o(pe_wdata)
  );

  cgra_rf #(.DW(DW), .DEPTH(RF_DEPTH)) u_rf (
    .clk_i, .rst_ni, .run_i, .host_we_i, .host_addr_i, .host_data_i,
    .rd_addr_i, .rd_data_o,
    .pe_raddr_i(pe_raddr), .pe_rdata_o(pe_rdata),
    .pe_we_i(pe_we), .pe_waddr_i(pe_waddr), .pe_wdata_i(pe_wdata)
  );

  assign cfg_err_o = err;

  assert_err_freezes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cfg_err_o) ##1 $stable(rd_addr_i) |-> $stable(rd_data_o));
endmodule

// File: tb/cgra_fuse_top_bench.sv
module cgra_fuse_top_bench;
  import cgra_fuse_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [15:0] cfg_word = '0;
  logic        run = 1'b0;
  logic        host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [31:0] host_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cgra_fuse_top u_cgra_fuse_top (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_word_i(cfg_word), .run_i(run), .host_we_i(host_we),
    .host_addr_i(host_addr), .host_data_i(host_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cfg_err_o(cfg_err)
  );

  function automatic logic [15:0] mk(int op, int sa, int sb, bit byp, int fld);
    return {3'(op), 3'(sa), 3'(sb), byp, 6'(fld)};
  endfunction

  function automatic logic [31:0] sentinel(int i);
    return 32'hA5A5_0000 | 32'(i);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(int idx, logic [15:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_word = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int i = 0; i < NPE; i++) load(i, 16'h0);
  endtask

  task automatic hwr(int a, logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = 3'(a); host_data = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic preload(logic [31:0] r0, logic [31:0] r1);
    hwr(0, r0); hwr(1, r1);
    for (int i = 2; i < 8; i++) hwr(i, sentinel(i));
  endtask

  task automatic step();
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
  endtask

  function automatic logic [31:0] rd(int a);
    return u_cgra_fuse_top.rd_data_o;
  endfunction

  task automatic read(int a, output logic [31:0] d);
    rd_addr = 3'(a); #1; d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // {op0, c0, op1, c1, op2, r0, r1, expected}; chain PE0 -> PE1 -> PE2 into r7
  localparam int VN = 5;
  localparam logic [116:0] VEC [VN] = '{
    {3'd1, 6'd40, 3'd1, 6'd10, 3'd3, 32'd100,        32'd2,     32'd37},
    {3'd2, 6'd8,  3'd1, 6'd7,  3'd4, 32'd5,          32'd4,     32'd64},
    {3'd4, 6'd16, 3'd3, 6'd8,  3'd2, 32'd3,          32'h100,   32'h200},
    {3'd1, 6'd0,  3'd2, 6'd1,  3'd1, 32'd0,          32'd0,     32'hFFFF_FFFF},
    {3'd1, 6'd48, 3'd3, 6'd3,  3'd4, 32'hFFFF_FFF0,  32'd1,     32'd8}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    for (int i = 0; i < 8; i++) begin
      read(i, d); check("R10 reset entry", d, 32'h0);
    end
    check("R8 reset err", 32'(cfg_err), 32'h0);

    // R1 R2 R4 R5 fused three-operation chains, one execute cycle
    for (int v = 0; v < VN; v++) begin
      logic [2:0]  op0, op1, op2;
      logic [5:0]  c0, c1;
      logic [31:0] r0, r1, ex, keep;
      {op0, c0, op1, c1, op2, r0, r1, ex} = VEC[v];
      do_reset();
      preload(r0, r1);
      load(0, mk(op0, 0, 1, 1'b1, c0));
      load(1, mk(op1, 5, 1, 1'b1, c1));
      load(2, mk(op2, 5, 0, 1'b0, 6'o71));
      check("R8 legal chain err", 32'(cfg_err), 32'h0);
      step();
      read(7, d); check("R1_R2_R4 chain result", d, ex);
      keep = (c0[5:3] == 0) ? r0 : (c0[5:3] == 1) ? r1 : sentinel(int'(c0[5:3]));
      read(int'(c0[5:3]), d); check("R5 bypassed PE no write", d, keep);
    end

    // R6 registered output seen on the next execute cycle only
    do_reset();
    preload(32'd1000, 32'd0);
    load(0, mk(1, 0, 1, 1'b0, 6'o20));   // r2 = r0 + 16
    load(1, mk(1, 5, 1, 1'b0, 6'o30));   // r3 = W + 24
    step();
    read(3, d); check("R6 first cycle neighbour reads 0", d, 32'd24);
    read(2, d); check("R6 registered write", d, 32'd1016);
    step();
    read(3, d); check("R6 second cycle sees registered value", d, 32'd1040);

    // R3 off-grid neighbour reads 0
    do_reset();
    preload(32'd7, 32'd0);
    load(0, mk(1, 2, 1, 1'b0, 6'o31));   // north of PE0 is off grid
    step();
    read(3, d); check("R3 off-grid neighbour", d, 32'd25);

    // R9 write conflict: PE0 and PE4 both target r3
    do_reset();
    preload(32'd100, 32'd0);
    load(4, mk(2, 0, 1, 1'b0, 6'o30));   // r3 = 100 - 24
    load(0, mk(1, 0, 1, 1'b0, 6'o30));   // r3 = 100 + 24
    step();
    read(3, d); check("R9 lower PE wins", d, 32'd124);

    // R7 two chains in different rows in one cycle
    do_reset();
    preload(32'd100, 32'd2);
    load(0,  mk(1, 0, 1, 1'b1, 40));
    load(1,  mk(1, 5, 1, 1'b1, 10));
    load(2,  mk(3, 5, 0, 1'b0, 6'o71));
    load(12, mk(2, 0, 1, 1'b1, 8));
    load(13, mk(1, 5, 1, 1'b1, 4));
    load(14, mk(4, 5, 0, 1'b0, 6'o61));
    step();
    read(7, d); check("R7 row0 chain", d, 32'd37);
    read(6, d); check("R7 row3 chain", d, 32'd384);

    // R8 four-long chain rejected
    do_reset();
    preload(32'd1, 32'd1);
    load(0, mk(1, 0, 1, 1'b1, 8));
    load(1, mk(1, 5, 1, 1'b1, 1));
    load(2, mk(1, 5, 1, 1'b1, 1));
    load(3, mk(1, 5, 0, 1'b0, 6'o71));
    check("R8 chain of four err", 32'(cfg_err), 32'h1);
    step();
    read(7, d); check("R8 no write under err", d, sentinel(7));

    // R8 bypass loop rejected
    clear_cfg();
    check("R8 cleared err", 32'(cfg_err), 32'h0);
    load(0, mk(1, 4, 1, 1'b1, 1));
    load(1, mk(1, 5, 1, 1'b1, 1));
    check("R8 loop err", 32'(cfg_err), 32'h1);

    // R10 host write ignored while running
    clear_cfg();
    @(negedge clk); run = 1'b1; host_we = 1'b1; host_addr = 3'd4; host_data = 32'hDEAD_BEEF;
    @(negedge clk); run = 1'b0; host_we = 1'b0;
    read(4, d); check("R10 host write ignored during run", d, sentinel(4));
    hwr(4, 32'h1234_5678);
    read(4, d); check("R10 host write when idle", d, 32'h1234_5678);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule